// File: doc/BRIEF.md
# Multichannel Audio Sample FIFO

This block buffers audio samples for one direction of a serial audio port. A register-bus side writes or reads 24-bit sample words, and a serializer side consumes or supplies one sample at a time. In playback mode the bus fills the buffer and the serializer drains it. In capture mode the serializer fills it and the bus drains it.

The usable capacity follows from a 3-bit RAM size code and the active channel count. Channel counts that are not a power of two are rounded up to the next power of two for grouping, so some RAM goes unused. Software sees a status word with the stored level in frames, plus two sticky error flags. It can also enable a half-level interrupt request and empty the buffer with a self-clearing control bit. The sample RAM is an internal array with `RAM_DEPTH` words, and `RAM_DEPTH` must be a power of two.

Top module: `audio_sample_fifo`

## Requirements
- R1: Base capacity is 256 << `cfg_size` words, clamped to `RAM_DEPTH`. A channel count of 0 counts as 1. The per-channel depth is the base halved once per doubling needed to reach the channel count (1, 2, 4 or 8). Capacity in words is that depth times the channel count; for example, size 1 with 3 channels holds 384 words.
- R2: Words leave in the order they were accepted. `head_data` shows the oldest stored word, or zero when the buffer is empty, and a pop consumes it.
- R3: A push that finds the buffer at capacity is dropped, even when a pop happens in the same cycle. It sets the sticky overflow flag at status bit 4.
- R4: A pop from an empty buffer returns zero and leaves the level at zero. It sets the sticky underflow flag at status bit 0.
- R5: Status bits [16:8] give the stored word count divided by the channel count, saturated at 511. All other status bits except 4 and 0 read zero.
- R6: A status write with data equal to zero clears both error flags. A status write with any non-zero value changes nothing. If a flag is set and cleared in the same cycle, the set wins.
- R7: A control write with bit 0 set empties the buffer in one cycle. It leaves the error flags unchanged and takes priority over a push or pop in the same cycle. Bit 0 is not stored.
- R8: Every control write stores bit 20 as the interrupt enable. When enabled, `irq` is high in playback while the word count is at most half the capacity, and in capture while it is at least half.
- R9: Only bits [23:0] of a bus write are kept. With `cfg_w16` set, bits [15:0] are stored left-aligned in [23:8] with a zero low byte.
- R10: In playback (`cfg_play`=1), `host_wr` pushes and `ser_pop` pops. In capture, `ser_push` pushes and `host_rd` pops. Strobes from the inactive side are ignored.
- R11: A push and a pop in the same cycle on a buffer that is neither empty nor full both take effect, and the level does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_size | input | 3 | RAM size code |
| cfg_chans | input | 4 | Active channel count |
| cfg_play | input | 1 | 1 = playback, 0 = capture |
| cfg_w16 | input | 1 | Left-align 16-bit bus samples |
| host_wr | input | 1 | Bus sample write strobe |
| host_wdata | input | 32 | Bus sample write data |
| host_rd | input | 1 | Bus sample read strobe |
| ser_push | input | 1 | Serializer sample strobe (capture) |
| ser_wdata | input | 24 | Serializer sample data |
| ser_pop | input | 1 | Serializer sample request (playback) |
| ctl_wr | input | 1 | Control register write |
| ctl_wdata | input | 32 | Control data: bit 20 interrupt enable, bit 0 clear |
| stat_wr | input | 1 | Status register write |
| stat_wdata | input | 32 | Status write data |
| head_data | output | 24 | Oldest stored sample, zero when empty |
| status | output | 32 | Level [16:8], overflow bit 4, underflow bit 0 |
| irq | output | 1 | Half-level interrupt request |

## Verification
Every stimulus lands at one rising edge, and its effect on `head_data`, `status` and `irq` is visible right after that edge, because all three are decoded combinationally from registered state. The bench drives inputs on the falling edge and waits for the next rising edge. It then compares the outputs at the following falling edge with a queue model that was advanced for that same edge. Overflow, underflow, flag clearing and the clear bit are therefore each checked exactly one cycle after the strobe that caused them.

// File: rtl/afifo_pkg.sv
package afifo_pkg;
    localparam int SMP_W       = 24;
    localparam int BASE_WORDS  = 256;
    localparam int LVL_W       = 9;
    localparam int LVL_MAX     = (1 << LVL_W) - 1;
    localparam int IRQ_SEL_BIT = 20;
    localparam int CLR_BIT     = 0;
    typedef logic [SMP_W-1:0] sample_t;
endpackage

// File: rtl/afifo_geom.sv
module afifo_geom #(
    parameter int RAM_DEPTH = 512,
    parameter int MAX_CH    = 8,
    parameter int CH_W      = 4,
    parameter int CW        = 10
) (
    input  logic [2:0]      size_code,
    input  logic [CH_W-1:0] chans,
    output logic [CH_W-1:0] chans_eff,
    output logic [CW-1:0]   cap_words
);
    import afifo_pkg::*;
    localparam int SH_MAX = $clog2(MAX_CH);

    always_comb begin
        int base_w;
        int grp_sh;
        base_w = BASE_WORDS << size_code;
        if (base_w > RAM_DEPTH) base_w = RAM_DEPTH;
        if (chans == '0)
            chans_eff = CH_W'(1);
        else if (int'(chans) > MAX_CH)
            chans_eff = CH_W'(MAX_CH);
        else
            chans_eff = chans;
        grp_sh = 0;
        for (int k = 0; k < SH_MAX; k++)
            if ((1 << k) < int'(chans_eff)) grp_sh = k + 1;
        cap_words = CW'((base_w >> grp_sh) * int'(chans_eff));
    end
endmodule

// File: rtl/afifo_core.sv
module afifo_core #(
    parameter int RAM_DEPTH = 512,
    parameter int CW        = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CW-1:0]       cap_words,
    input  logic                push,
    input  afifo_pkg::sample_t  push_data,
    input  logic                pop,
    input  logic                flush,
    input  logic                ctl_wr,
    input  logic                ctl_irq_sel,
    input  logic                flag_clr,
    output afifo_pkg::sample_t  head_data,
    output logic [CW-1:0]       count,
    output logic                ovf,
    output logic                unf,
    output logic                irq_sel
);
    import afifo_pkg::*;
    localparam int AW = $clog2(RAM_DEPTH);

    typedef struct packed {
        logic [AW-1:0] wr_ptr;
        logic [AW-1:0] rd_ptr;
        logic [CW-1:0] count;
        logic          ovf;
        logic          unf;
        logic          irq_sel;
    } core_st_t;

    core_st_t st_q, st_d;
    sample_t  mem [RAM_DEPTH];
    logic     acc_push, acc_pop;

    always_comb begin
        acc_push = push && (st_q.count < cap_words) && !flush;
        acc_pop  = pop && (st_q.count != '0) && !flush;
        st_d = st_q;
        if (ctl_wr) st_d.irq_sel = ctl_irq_sel;
        if (flag_clr) begin
            st_d.ovf = 1'b0;
            st_d.unf = 1'b0;
        end
        if (push && (st_q.count >= cap_words)) st_d.ovf = 1'b1;
        if (pop && (st_q.count == '0))         st_d.unf = 1'b1;
        if (flush) begin
            st_d.wr_ptr = '0;
            st_d.rd_ptr = '0;
            st_d.count  = '0;
        end else begin
            if (acc_push) st_d.wr_ptr = st_q.wr_ptr + AW'(1);
            if (acc_pop)  st_d.rd_ptr = st_q.rd_ptr + AW'(1);
            st_d.count = st_q.count + CW'(acc_push) - CW'(acc_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (acc_push) mem[st_q.wr_ptr] <= push_data;
    end

    assign head_data = (st_q.count == '0) ? '0 : mem[st_q.rd_ptr];
    assign count     = st_q.count;
    assign ovf       = st_q.ovf;
    assign unf       = st_q.unf;
    assign irq_sel   = st_q.irq_sel;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.count <= cap_words); // R3
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !flush && st_q.count >= cap_words) |=> $stable(st_q.count)); // R3
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ovf && !flag_clr) |=> st_q.ovf); // R3
    AST_EMPTY_POP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !flush && st_q.count == '0) |=> (st_q.count == '0 && st_q.unf)); // R4
    AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (st_q.count == '0)); // R7
    AST_FLUSH_KEEPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !flag_clr && st_q.unf) |=> st_q.unf); // R7
endmodule

// File: rtl/audio_sample_fifo.sv
module audio_sample_fifo #(
    parameter int RAM_DEPTH = 512,
    parameter int MAX_CH    = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [2:0]  cfg_size,
    input  logic [3:0]  cfg_chans,
    input  logic        cfg_play,
    input  logic        cfg_w16,
    input  logic        host_wr,
    input  logic [31:0] host_wdata,
    input  logic        host_rd,
    input  logic        ser_push,
    input  logic [23:0] ser_wdata,
    input  logic        ser_pop,
    input  logic        ctl_wr,
    input  logic [31:0] ctl_wdata,
    input  logic        stat_wr,
    input  logic [31:0] stat_wdata,
    output logic [23:0] head_data,
    output logic [31:0] status,
    output logic        irq
);
    import afifo_pkg::*;
    localparam int CH_W = 4;
    localparam int CW   = $clog2(RAM_DEPTH) + 1;

    logic [CH_W-1:0] chans_eff;
    logic [CW-1:0]   cap_words, count, frames, half_cap;
    logic            push, pop, flush, flag_clr, ovf, unf, irq_sel;
    sample_t         host_smp, push_data;
    logic [LVL_W-1:0] lvl;

    afifo_geom #(.RAM_DEPTH(RAM_DEPTH), .MAX_CH(MAX_CH), .CH_W(CH_W), .CW(CW)) u_geom (
        .size_code (cfg_size),
        .chans     (cfg_chans),
        .chans_eff (chans_eff),
        .cap_words (cap_words)
    );

    // R9: keep 24 bits, or left-align a 16-bit sample
    assign host_smp  = cfg_w16 ? {host_wdata[15:0], 8'h00} : host_wdata[SMP_W-1:0];
    // R10: direction picks the producer and the consumer
    assign push      = cfg_play ? host_wr  : ser_push;
    assign pop       = cfg_play ? ser_pop  : host_rd;
    assign push_data = cfg_play ? host_smp : ser_wdata;
    assign flush     = ctl_wr && ctl_wdata[CLR_BIT];
    assign flag_clr  = stat_wr && (stat_wdata == '0);

    afifo_core #(.RAM_DEPTH(RAM_DEPTH), .CW(CW)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_words   (cap_words),
        .push        (push),
        .push_data   (push_data),
        .pop         (pop),
        .flush       (flush),
        .ctl_wr      (ctl_wr),
        .ctl_irq_sel (ctl_wdata[IRQ_SEL_BIT]),
        .flag_clr    (flag_clr),
        .head_data   (head_data),
        .count       (count),
        .ovf         (ovf),
        .unf         (unf),
        .irq_sel     (irq_sel)
    );

    always_comb begin
        frames = count / CW'(chans_eff);
        if (int'(frames) > LVL_MAX) lvl = LVL_W'(LVL_MAX);
        else                        lvl = LVL_W'(frames);
        half_cap = cap_words >> 1;
        status = {15'b0, lvl, 3'b0, ovf, 3'b0, unf};
        irq = irq_sel && (cfg_play ? (count <= half_cap) : (count >= half_cap));
    end
endmodule

// File: tb/audio_sample_fifo_bench.sv
module audio_sample_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  cfg_size;
    logic [3:0]  cfg_chans;
    logic        cfg_play, cfg_w16;
    logic        host_wr, host_rd, ser_push, ser_pop, ctl_wr, stat_wr;
    logic [31:0] host_wdata, ctl_wdata, stat_wdata;
    logic [23:0] ser_wdata;
    logic [23:0] head_data;
    logic [31:0] status;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    logic [23:0] m_q[$];
    bit m_ovf, m_unf, m_ien;

    always #5 clk = ~clk;

    audio_sample_fifo u_audio_sample_fifo (
        .clk(clk), .rst_n(rst_n), .cfg_size(cfg_size), .cfg_chans(cfg_chans),
        .cfg_play(cfg_play), .cfg_w16(cfg_w16), .host_wr(host_wr),
        .host_wdata(host_wdata), .host_rd(host_rd), .ser_push(ser_push),
        .ser_wdata(ser_wdata), .ser_pop(ser_pop), .ctl_wr(ctl_wr),
        .ctl_wdata(ctl_wdata), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
        .head_data(head_data), .status(status), .irq(irq)
    );

    function automatic int f_chans(input logic [3:0] c);
        if (c == 0) return 1;
        if (c > 8) return 8;
        return int'(c);
    endfunction

    function automatic int f_cap(input logic [2:0] sz, input logic [3:0] c);
        int b = 256 << sz;
        int n = f_chans(c);
        int s = 0;
        if (b > 512) b = 512;
        while ((1 << s) < n) s++;
        return (b >> s) * n;
    endfunction

    function automatic logic [31:0] f_status();
        int lv = m_q.size() / f_chans(cfg_chans);
        if (lv > 511) lv = 511;
        return (32'(lv) << 8) | (32'(m_ovf) << 4) | 32'(m_unf);
    endfunction

    function automatic bit f_irq();
        int cap = f_cap(cfg_size, cfg_chans);
        if (!m_ien) return 1'b0;
        return cfg_play ? (m_q.size() <= cap / 2) : (m_q.size() >= cap / 2);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_all();
        chk("R2 head", {8'h0, head_data}, {8'h0, (m_q.size() > 0) ? m_q[0] : 24'h0});
        chk("R5 status", status, f_status());
        chk("R8 irq", {31'h0, irq}, {31'h0, f_irq()});
    endtask

    // one cycle: apply strobes, advance the model for the coming edge, check after it
    task automatic cyc(input bit hw, input logic [31:0] hd, input bit sp, input logic [23:0] sd,
                       input bit spop, input bit hr, input bit cw, input logic [31:0] cd,
                       input bit sw, input logic [31:0] sdat);
        int cap = f_cap(cfg_size, cfg_chans);
        int cnt = m_q.size();
        bit pu = cfg_play ? hw : sp;
        bit po = cfg_play ? spop : hr;
        logic [23:0] d = cfg_play ? (cfg_w16 ? {hd[15:0], 8'h00} : hd[23:0]) : sd;
        host_wr = hw; host_wdata = hd; ser_push = sp; ser_wdata = sd; ser_pop = spop;
        host_rd = hr; ctl_wr = cw; ctl_wdata = cd; stat_wr = sw; stat_wdata = sdat;
        if (cw) m_ien = cd[20];
        if (sw && sdat == 0) begin m_ovf = 0; m_unf = 0; end
        if (pu && cnt >= cap) m_ovf = 1;
        if (po && cnt == 0) m_unf = 1;
        if (cw && cd[0]) m_q.delete();
        else begin
            if (po && cnt > 0) void'(m_q.pop_front());
            if (pu && cnt < cap) m_q.push_back(d);
        end
        @(posedge clk);
        @(negedge clk);
        host_wr = 0; ser_push = 0; ser_pop = 0; host_rd = 0; ctl_wr = 0; stat_wr = 0;
        chk_all();
    endtask

    task automatic do_push(input logic [31:0] d);
        if (cfg_play) cyc(1, d, 0, 0, 0, 0, 0, 0, 0, 0);
        else          cyc(0, 0, 1, d[23:0], 0, 0, 0, 0, 0, 0);
    endtask
    task automatic do_pop();
        if (cfg_play) cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 0);
        else          cyc(0, 0, 0, 0, 0, 1, 0, 0, 0, 0);
    endtask
    task automatic do_flush();
        cyc(0, 0, 0, 0, 0, 0, 1, 32'h1 | (32'(m_ien) << 20), 0, 0);
    endtask
    task automatic stat_write(input logic [31:0] v);
        cyc(0, 0, 0, 0, 0, 0, 0, 0, 1, v);
    endtask
    task automatic set_cfg(input logic [2:0] sz, input logic [3:0] c, input bit pl, input bit w);
        do_flush();
        cfg_size = sz; cfg_chans = c; cfg_play = pl; cfg_w16 = w;
        #1;
        chk_all();
    endtask

    // R1: exactly cap words are accepted, the next push overflows
    task automatic fill_to_cap(input string tag);
        int cap = f_cap(cfg_size, cfg_chans);
        stat_write(0);
        for (int i = 0; i < cap; i++) do_push(32'($urandom));
        chk({tag, " R1 no overflow at capacity"}, {31'h0, status[4]}, 32'h0);
        do_push(32'h00ABCDEF);
        chk({tag, " R1/R3 overflow past capacity"}, {31'h0, status[4]}, 32'h1);
    endtask

    task automatic rand_run(input int n);
        for (int i = 0; i < n; i++) begin
            bit pu = ($urandom % 100) < ((i < n / 2) ? 70 : 30);
            bit po = ($urandom % 100) < ((i < n / 2) ? 30 : 70);
            bit sw = ($urandom % 100) < 2;
            cyc(pu, $urandom, pu, 24'($urandom), po, po, 0, 0, sw, sw ? 32'h0 : 32'h0);
        end
    endtask

    initial begin
        #2000000;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        rst_n = 0; cfg_size = 0; cfg_chans = 2; cfg_play = 1; cfg_w16 = 0;
        host_wr = 0; host_rd = 0; ser_push = 0; ser_pop = 0; ctl_wr = 0; stat_wr = 0;
        host_wdata = 0; ctl_wdata = 0; stat_wdata = 0; ser_wdata = 0;
        m_ovf = 0; m_unf = 0; m_ien = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R5 reset status", status, 32'h0);
        chk("R2 reset head", {8'h0, head_data}, 32'h0);
        chk("R8 reset irq", {31'h0, irq}, 32'h0);

        // R2/R9: order and 24-bit truncation
        do_push(32'hFF123456);
        chk("R9 upper byte dropped", {8'h0, head_data}, 32'h00123456);
        do_push(32'h00654321);
        do_pop();
        chk("R2 second word surfaces", {8'h0, head_data}, 32'h00654321);
        // R11: simultaneous push and pop
        cyc(1, 32'h000A0B0C, 0, 0, 1, 0, 0, 0, 0, 0);
        chk("R11 level unchanged", {23'h0, status[16:8]}, 32'h0);
        chk("R11 new word is head", {8'h0, head_data}, 32'h000A0B0C);
        do_pop();
        // R4: underflow
        do_pop();
        chk("R4 underflow flag", {31'h0, status[0]}, 32'h1);
        chk("R4 zero returned", {8'h0, head_data}, 32'h0);
        // R6: nonzero write ignored, zero clears
        stat_write(32'h11);
        chk("R6 nonzero write ignored", {31'h0, status[0]}, 32'h1);
        stat_write(32'h0);
        chk("R6 zero write clears", status, 32'h0);

        // R9: 16-bit left alignment
        set_cfg(0, 2, 1, 1);
        do_push(32'hDEAD_BEEF);
        chk("R9 16-bit left aligned", {8'h0, head_data}, 32'h00BEEF00);

        // R1/R3/R5: size 0, 2 channels -> 256 words, 128 frames
        set_cfg(0, 2, 1, 0);
        fill_to_cap("s0c2");
        chk("R5 frames 128", {23'h0, status[16:8]}, 32'd128);
        // R3: push at full with pop is still dropped
        cyc(1, 32'h1, 0, 0, 1, 0, 0, 0, 0, 0);
        chk("R3 full with pop drops push", {23'h0, status[16:8]}, 32'd127);
        // R7: clear keeps flags
        do_flush();
        chk("R7 cleared level", {23'h0, status[16:8]}, 32'h0);
        chk("R7 overflow kept", {31'h0, status[4]}, 32'h1);

        // R8: interrupt in playback
        cyc(0, 0, 0, 0, 0, 0, 1, 32'h0010_0000, 0, 0);
        chk("R8 playback empty irq", {31'h0, irq}, 32'h1);
        for (int i = 0; i < 129; i++) do_push(32'(i));
        chk("R8 above half no irq", {31'h0, irq}, 32'h0);

        // R1 geometry variants
        set_cfg(1, 3, 1, 0);
        fill_to_cap("s1c3");
        chk("R1 384 words as 128 frames", {23'h0, status[16:8]}, 32'd128);
        set_cfg(0, 5, 1, 0);
        fill_to_cap("s0c5");
        set_cfg(7, 0, 1, 0);
        fill_to_cap("s7c0");
        chk("R5 saturated level", {23'h0, status[16:8]}, 32'd511);

        // R10: capture mode, host writes ignored
        set_cfg(0, 2, 0, 0);
        stat_write(0);
        cyc(1, 32'h00777777, 0, 0, 1, 0, 0, 0, 0, 0);
        chk("R10 host write ignored", status, 32'h0);
        do_push(32'h00ABCDEF);
        chk("R10 serializer push lands", {8'h0, head_data}, 32'h00ABCDEF);
        chk("R8 capture below half", {31'h0, irq}, 32'h0);
        for (int i = 0; i < 127; i++) do_push(32'(i));
        chk("R8 capture at half", {31'h0, irq}, 32'h1);

        // random phases
        set_cfg(0, 2, 1, 0);
        rand_run(1200);
        set_cfg(1, 6, 0, 0);
        rand_run(1200);
        set_cfg(0, 1, 1, 1);
        rand_run(1200);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule